// File: doc/BRIEF.md
# Glide-Controlled Fractional Divider Selector

This block sits in front of the feedback divider of a frequency synthesizer loop. It holds four fractional divider profiles. A 2-bit profile number picks one of them as the target. The profile number comes either from two hardware pins or from a 2-bit software field, and a source input chooses between the two. The block does not load a newly chosen target into the divider at once. On every pulse of a rate tick it moves the active divider word toward the target by at most a programmable step. This keeps the loop from overshooting when the frequency changes.

The glide runs on every change of target, and no enable is needed for it. A target can change in two ways: the profile number changes, or the profile being used is rewritten. When the target changes during a glide, the block takes the new target at once and keeps moving from wherever the active word is at that moment. A busy flag shows that the active word and the target differ.

Top module: `freq_step_ctrl`

## Requirements
- R1: Each of the four slots holds a 24-bit word: bits 23:16 are the integer part and bits 15:0 are the fraction. A clock edge with `wr_en` high stores `wr_data` into the slot numbered by `wr_slot`.
- R2: With `sel_src` = 0, the target is the slot numbered by `sel_hw`. With `sel_src` = 1, it is the slot numbered by `sel_sw`, and `sel_hw` has no effect.
- R3: On a tick edge where `div_out` is below the target by more than the step, `div_out` rises by exactly the step.
- R4: On a tick edge where `div_out` is above the target by more than the step, `div_out` falls by exactly the step.
- R5: On a tick edge where `div_out` is within one step of the target, `div_out` becomes the target. It never moves past the target.
- R6: `div_out` does not change on a clock edge without `tick`, even when the target changes.
- R7: `busy` is high exactly when `div_out` differs from the currently selected target.
- R8: A change of target during a glide takes effect at once, and the glide continues from the present `div_out`.
- R9: After reset, all slots and `div_out` hold 24'h40_0000 (profile 0), and `busy` is low.
- R10: A `step_size` of zero moves `div_out` by one LSB per tick.
- R11: Rewriting the selected slot retargets the glide. If the write and a tick fall on the same edge, that step heads for the slot's old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sel_src | input | 1 | Profile number source: 0 = pins, 1 = software field |
| sel_hw | input | 2 | Profile number from pins |
| sel_sw | input | 2 | Profile number from software field |
| wr_en | input | 1 | Profile write strobe |
| wr_slot | input | 2 | Slot that the write goes to |
| wr_data | input | 24 | Profile word, 8.16 fixed point |
| step_size | input | 16 | Largest move per tick, in LSBs (0 means 1) |
| tick | input | 1 | Step-rate pulse |
| div_out | output | 24 | Active divider word |
| busy | output | 1 | Active word differs from target |

## Verification
Two events can fall on the same edge. The first is a change of target, caused either by a new profile number or by a write to the selected slot. The second is a tick. The bench makes them coincide on purpose. A profile number change is applied on the same edge as a tick, so that step must already head for the new slot. A write to the selected slot is applied on a tick edge, so that step must still head for the slot's old contents and the following ticks head for the new word. A reference model in the bench restates the step arithmetic as a signed distance. It compares `div_out` and `busy` every cycle through full sweeps over all ordered slot pairs, several step sizes and two tick rates.

// File: rtl/fstep_pkg.sv
package fstep_pkg;
  localparam int FSTEP_SLOTS = 4;
  localparam int FSTEP_SEL_W = 2;

  typedef enum logic [1:0] {
    DIR_HOLD = 2'd0,
    DIR_UP   = 2'd1,
    DIR_DOWN = 2'd2
  } fstep_dir_e;

  typedef enum logic {
    SRC_PINS = 1'b0,
    SRC_REG  = 1'b1
  } fstep_src_e;
endpackage

// File: rtl/fstep_sel.sv
module fstep_sel
  import fstep_pkg::*;
#(
  parameter int SEL_W = FSTEP_SEL_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sel_src,
  input  logic [SEL_W-1:0] sel_hw,
  input  logic [SEL_W-1:0] sel_sw,
  output logic [SEL_W-1:0] sel_now,
  output logic             sel_chg
);
  logic [SEL_W-1:0] sel_prev;

  // source choice: pins or software field
  assign sel_now = (fstep_src_e'(sel_src) == SRC_REG) ? sel_sw : sel_hw;

  always_ff @(posedge clk) begin
    if (!rst_n) sel_prev <= '0;
    else        sel_prev <= sel_now;
  end

  // profile number differs from last cycle
  assign sel_chg = (sel_prev != sel_now);
endmodule

// File: rtl/fstep_prof_bank.sv
module fstep_prof_bank #(
  parameter int              DW      = 24,
  parameter int              SLOTS   = 4,
  parameter int              SEL_W   = 2,
  parameter logic [DW-1:0]   RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [SEL_W-1:0] wr_slot,
  input  logic [DW-1:0]    wr_data,
  input  logic [SEL_W-1:0] rd_sel,
  output logic [DW-1:0]    rd_data
);
  logic [DW-1:0] slot_q [SLOTS];

  for (genvar g = 0; g < SLOTS; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n)                                  slot_q[g] <= RST_VAL;
      else if (wr_en && (wr_slot == SEL_W'(g)))    slot_q[g] <= wr_data;
    end
  end

  assign rd_data = slot_q[rd_sel];
endmodule

// File: rtl/fstep_ramp.sv
module fstep_ramp
  import fstep_pkg::*;
#(
  parameter int            DW      = 24,
  parameter int            STEP_W  = 16,
  parameter logic [DW-1:0] RST_VAL = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic [STEP_W-1:0] step_size,
  input  logic [DW-1:0]     target,
  output logic [DW-1:0]     active,
  output logic              busy,
  output logic              step_fire,
  output logic              arrive,
  output fstep_dir_e        dir
);
  // zero step is promoted to one LSB
  function automatic logic [DW-1:0] eff_step(input logic [STEP_W-1:0] s);
    eff_step = (s == '0) ? DW'(1) : DW'(s);
  endfunction

  // one bounded move of cur toward tgt, clamped on arrival
  function automatic logic [DW-1:0] ramp_next(input logic [DW-1:0] cur,
                                              input logic [DW-1:0] tgt,
                                              input logic [DW-1:0] stp);
    logic [DW-1:0] gap;
    if (cur < tgt) begin
      gap       = tgt - cur;
      ramp_next = (gap > stp) ? cur + stp : tgt;
    end else if (cur > tgt) begin
      gap       = cur - tgt;
      ramp_next = (gap > stp) ? cur - stp : tgt;
    end else begin
      ramp_next = cur;
    end
  endfunction

  logic [DW-1:0] act_q;
  logic [DW-1:0] act_nxt;
  logic [DW-1:0] stp_w;

  assign stp_w   = eff_step(step_size);
  assign act_nxt = ramp_next(act_q, target, stp_w);

  always_comb begin
    if (act_q < target)      dir = DIR_UP;
    else if (act_q > target) dir = DIR_DOWN;
    else                     dir = DIR_HOLD;
  end

  assign busy      = (dir != DIR_HOLD);
  assign step_fire = tick && busy;
  assign arrive    = step_fire && (act_nxt == target);

  always_ff @(posedge clk) begin
    if (!rst_n)         act_q <= RST_VAL;
    else if (step_fire) act_q <= act_nxt;
  end

  assign active = act_q;
endmodule

// File: rtl/freq_step_ctrl.sv
module freq_step_ctrl
  import fstep_pkg::*;
#(
  parameter int                         INT_W   = 8,
  parameter int                         FRAC_W  = 16,
  parameter int                         STEP_W  = 16,
  parameter logic [INT_W+FRAC_W-1:0]    DEF_DIV = 24'h40_0000
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          sel_src,
  input  logic [FSTEP_SEL_W-1:0]        sel_hw,
  input  logic [FSTEP_SEL_W-1:0]        sel_sw,
  input  logic                          wr_en,
  input  logic [FSTEP_SEL_W-1:0]        wr_slot,
  input  logic [INT_W+FRAC_W-1:0]       wr_data,
  input  logic [STEP_W-1:0]             step_size,
  input  logic                          tick,
  output logic [INT_W+FRAC_W-1:0]       div_out,
  output logic                          busy
);
  localparam int DW = INT_W + FRAC_W;

  logic [FSTEP_SEL_W-1:0] sel_w;
  logic                   sel_chg_w;
  logic [DW-1:0]          tgt_w;
  logic                   step_fire_w;
  logic                   arrive_w;
  fstep_dir_e             dir_w;

  fstep_sel #(.SEL_W(FSTEP_SEL_W)) u_sel (
    .clk     (clk),
    .rst_n   (rst_n),
    .sel_src (sel_src),
    .sel_hw  (sel_hw),
    .sel_sw  (sel_sw),
    .sel_now (sel_w),
    .sel_chg (sel_chg_w)
  );

  fstep_prof_bank #(
    .DW(DW), .SLOTS(FSTEP_SLOTS), .SEL_W(FSTEP_SEL_W), .RST_VAL(DEF_DIV)
  ) u_bank (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_slot (wr_slot),
    .wr_data (wr_data),
    .rd_sel  (sel_w),
    .rd_data (tgt_w)
  );

  fstep_ramp #(.DW(DW), .STEP_W(STEP_W), .RST_VAL(DEF_DIV)) u_ramp (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .step_size (step_size),
    .target    (tgt_w),
    .active    (div_out),
    .busy      (busy),
    .step_fire (step_fire_w),
    .arrive    (arrive_w),
    .dir       (dir_w)
  );
endmodule

// File: rtl/fstep_chk.sv
module fstep_chk #(
  parameter int            DW      = 24,
  parameter int            STEP_W  = 16,
  parameter logic [DW-1:0] DEF_DIV = '0
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tick,
  input logic [STEP_W-1:0] step_size,
  input logic [DW-1:0]     div_out,
  input logic              busy,
  input logic [DW-1:0]     tgt,
  input logic              sel_chg,
  input logic              arrive
);
  logic [DW-1:0] ext_step;
  assign ext_step = (step_size == '0) ? DW'(1) : DW'(step_size);

  // R9
  reset_state_chk: assert property (@(posedge clk)
    $rose(rst_n) |-> (div_out == DEF_DIV) && !busy);

  // R6
  no_tick_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(div_out));

  // R3
  up_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && (div_out < tgt) && ((tgt - div_out) > ext_step))
      |=> div_out == $past(div_out) + $past(ext_step));

  // R4
  down_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && (div_out > tgt) && ((div_out - tgt) > ext_step))
      |=> div_out == $past(div_out) - $past(ext_step));

  // R5
  no_pass_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && (div_out < tgt)) |=> (div_out <= $past(tgt)) && (div_out > $past(div_out)));

  // R5
  no_pass_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && (div_out > tgt)) |=> (div_out >= $past(tgt)) && (div_out < $past(div_out)));

  // R7
  busy_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !tick && !sel_chg) |=> busy || !$stable(tgt) || $changed(sel_chg));

  // R5
  arrive_land_chk: assert property (@(posedge clk) disable iff (!rst_n)
    arrive |=> div_out == $past(tgt));
endmodule

bind freq_step_ctrl fstep_chk #(.DW(DW), .STEP_W(STEP_W), .DEF_DIV(DEF_DIV)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .tick      (tick),
  .step_size (step_size),
  .div_out   (div_out),
  .busy      (busy),
  .tgt       (tgt_w),
  .sel_chg   (sel_chg_w),
  .arrive    (arrive_w)
);

// File: tb/sim_freq_step_ctrl.sv
`timescale 1ns/1ps
module sim_freq_step_ctrl;
  localparam logic [23:0] DEF = 24'h40_0000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sel_src = 1'b0;
  logic [1:0]  sel_hw = 2'd0;
  logic [1:0]  sel_sw = 2'd0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_slot = 2'd0;
  logic [23:0] wr_data = '0;
  logic [15:0] step_size = 16'd1;
  logic        tick = 1'b0;
  logic [23:0] div_out;
  logic        busy;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  logic [23:0] m_act;
  logic [23:0] m_prof [4];
  logic [23:0] pv [4];

  always #4 clk = ~clk;

  freq_step_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .sel_src(sel_src), .sel_hw(sel_hw), .sel_sw(sel_sw),
    .wr_en(wr_en), .wr_slot(wr_slot), .wr_data(wr_data), .step_size(step_size),
    .tick(tick), .div_out(div_out), .busy(busy)
  );

  function automatic logic [1:0] cur_sel();
    return sel_src ? sel_sw : sel_hw;
  endfunction

  // signed-distance model of one tick
  function automatic logic [23:0] model_step(logic [23:0] a, logic [23:0] t, logic [15:0] s);
    int d = int'(t) - int'(a);
    int m = (s == 0) ? 1 : int'(s);
    if (d > m)       return 24'(int'(a) + m);
    else if (d < -m) return 24'(int'(a) - m);
    else             return t;
  endfunction

  task automatic check(string tag);
    logic [23:0] t = m_prof[cur_sel()];
    logic eb = (m_act != t);
    n_cmp++;
    if (div_out !== m_act || busy !== eb) begin
      n_bad++;
      $display("FAIL %s: div_out=%h busy=%b expected div_out=%h busy=%b", tag, div_out, busy, m_act, eb);
    end
  endtask

  task automatic cyc(string tag);
    @(posedge clk);
    if (!rst_n) begin
      m_act = DEF;
      for (int i = 0; i < 4; i++) m_prof[i] = DEF;
    end else begin
      if (tick) m_act = model_step(m_act, m_prof[cur_sel()], step_size);
      if (wr_en) m_prof[wr_slot] = wr_data;
    end
    @(negedge clk);
    check(tag);
  endtask

  task automatic write_slot(logic [1:0] s, logic [23:0] d, string tag);
    wr_en = 1'b1; wr_slot = s; wr_data = d;
    cyc(tag);
    wr_en = 1'b0;
  endtask

  // tick every 'rate' cycles until model reaches target
  task automatic settle(int rate, string tag);
    for (int i = 0; i < 4000 && (m_act != m_prof[cur_sel()]); i++) begin
      tick = ((i % rate) == 0);
      cyc(tag);
    end
    tick = 1'b0;
    cyc(tag);
  endtask

  initial begin
    #(200000 * 8);
    n_bad++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [15:0] steps [6];
    steps = '{16'd0, 16'd1, 16'd2, 16'd5, 16'd16, 16'd300};
    pv = '{24'h40_0000, 24'h40_0025, 24'h3F_FFE0, 24'h40_0100};

    @(negedge clk);
    cyc("R9"); cyc("R9");
    rst_n = 1'b1;
    cyc("R9");

    // R1: load profiles while slot 0 is selected
    for (int s = 1; s < 4; s++) write_slot(2'(s), pv[s], "R1");
    step_size = 16'd300;
    for (int s = 0; s < 4; s++) begin
      sel_hw = 2'(s);
      settle(1, "R1");
    end

    // R3 R4 R5 R7: all ordered slot pairs, step sizes, tick rates
    for (int r = 1; r <= 3; r += 2)
      for (int k = 0; k < 6; k++)
        for (int a = 0; a < 4; a++)
          for (int b = 0; b < 4; b++) begin
            step_size = 16'd300;
            sel_hw = 2'(a);
            settle(1, "R5 R7");
            step_size = steps[k];
            sel_hw = 2'(b);
            settle(r, (pv[b] > pv[a]) ? "R3 R5 R7" : "R4 R5 R7");
          end

    // R6: target changes with no tick
    step_size = 16'd4;
    sel_hw = 2'd3;
    for (int i = 0; i < 6; i++) cyc("R6");
    sel_hw = 2'd2;
    for (int i = 0; i < 3; i++) cyc("R6");
    settle(1, "R6");

    // R8: reverse mid glide
    step_size = 16'd3;
    sel_hw = 2'd3;
    tick = 1'b1;
    for (int i = 0; i < 25; i++) cyc("R8");
    sel_hw = 2'd1;   // same edge as a tick
    cyc("R8");
    settle(1, "R8");

    // R10: zero step moves one LSB
    step_size = 16'd0;
    sel_hw = 2'd0;
    tick = 1'b1;
    for (int i = 0; i < 5; i++) cyc("R10");
    settle(1, "R10");

    // R2: software source; pins ignored
    step_size = 16'd40;
    sel_src = 1'b1; sel_sw = 2'd3; sel_hw = 2'd2;
    settle(1, "R2");
    sel_hw = 2'd0;
    tick = 1'b1;
    for (int i = 0; i < 4; i++) cyc("R2");
    tick = 1'b0;
    sel_src = 1'b0; sel_hw = 2'd1;
    settle(2, "R2");

    // R11: write the selected slot on a tick edge
    step_size = 16'd2;
    sel_hw = 2'd3;
    tick = 1'b1;
    for (int i = 0; i < 10; i++) cyc("R11");
    write_slot(2'd3, 24'h3F_FFF0, "R11");
    settle(1, "R11");
    // write to an unselected slot leaves the glide alone
    sel_hw = 2'd1;
    tick = 1'b1;
    write_slot(2'd2, 24'h40_0200, "R11");
    settle(1, "R11");
    sel_hw = 2'd2;
    step_size = 16'd300;
    settle(1, "R1");

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule